// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a small register-controlled peripheral that sits on a two-wire, open-drain serial bus. It watches a clock line and a bidirectional data line with a fast system clock. From these it finds the bus conditions that open and close a transaction. It then receives an eight-bit slave address, a command byte and, for write commands, one data byte. Each accepted byte is acknowledged by pulling the data line low for one bus clock.

The register block behind it sees a plain parallel interface. A one-cycle strobe carries each received command byte, and another carries each data byte. When the most significant bit of the command is set, the command is a read. In that case the block raises a read request in the same cycle as the command strobe. After the command acknowledge it shifts the byte presented on `rdByte` out onto the bus. The address has two parts: a fixed upper type nibble, and a lower nibble taken from four strap pins. A slave that does not match stays silent until the next start condition.

Top module: `tw_slave`

## Requirements
- R1: After reset, `sdaDriveLow`, `cmdValid`, `dataValid` and `rdReq` are all 0.
- R2: Bus activity is ignored until a start condition has been seen. A start condition is a falling data edge while the clock is high. Before it, no byte is acknowledged and no strobe fires.
- R3: A stop condition is a rising data edge while the clock is high. It ends the transaction. Bytes clocked after a stop and before a new start are not acknowledged and raise no strobe.
- R4: Bits are taken MSB first on rising clock edges. The first byte after a start is the address. Its bits 7..4 must equal 0101 and its bits 3..0 must equal `strapAddr`. On a full match the slave holds data low through the ninth clock, and the master reads that as an acknowledge.
- R5: On any address mismatch the slave acknowledges nothing and raises no strobe until the next start.
- R6: The byte after a matching address is the command. It is acknowledged, and `cmdValid` pulses for exactly one cycle with the byte on `cmdByte`. `cmdValid` and `dataValid` are never high together.
- R7: If the command has bit 7 = 0, the next byte is data. It is acknowledged, and `dataValid` pulses with it on `dataByte`. Any byte after that data byte is not acknowledged.
- R8: If the command has bit 7 = 1, `rdReq` pulses in the same cycle as `cmdValid`. After the command acknowledge, the slave sends `rdByte` MSB first. It then releases data for the master's acknowledge bit, whatever its level, and drives nothing further in that transaction.
- R9: A start condition inside a transaction returns the slave to address reception, with the bit count cleared.
- R10: The data output is only a pull-low enable. It becomes active only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired level) |
| strapAddr | input | 4 | Pin-strapped lower address nibble |
| rdByte | input | 8 | Byte returned to the master on a read command |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| cmdValid | output | 1 | One-cycle strobe for a received command byte |
| cmdByte | output | 8 | Last received command byte |
| dataValid | output | 1 | One-cycle strobe for a received data byte |
| dataByte | output | 8 | Last received data byte |
| rdReq | output | 1 | One-cycle request for `rdByte`, raised with a read command strobe |

## Verification
Two pairs of functions can land in the same system-clock cycle. A read command raises the command strobe and the read request in one cycle. The bench sends read commands and counts the cycles in which both outputs are high together, expecting exactly one such cycle per read. A start condition can also arrive in the middle of a byte, while the bit counter is advancing. The bench cuts a command byte after three bits with a fresh start. It then expects the next full address to be acknowledged and the following command to be reported unchanged.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_TX,
    ST_TXACK,
    ST_HOLD
  } twState_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic shiftIn;   // take one received bit
    logic ackOn;     // start pulling data low for an acknowledge
    logic relDrive;  // let data float high
    logic loadTx;    // load the read byte and drive its first bit
    logic nextTx;    // drive the next read bit
    logic cmdStb;    // publish the command byte
    logic dataStb;   // publish the data byte
  } twCtl_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] pipe;
  logic              prevLevel;

  // idle bus lines are high, so reset to high to avoid a false edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe      <= '1;
      prevLevel <= 1'b1;
    end else begin
      pipe      <= {pipe[STAGES-2:0], lineIn};
      prevLevel <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = level & ~prevLevel;
  assign fall  = ~level & prevLevel;

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclLevel,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   sdaRise,
  input  logic   sdaFall,
  input  logic   addrMatch,
  input  logic   cmdIsRead,
  output twCtl_t ctl
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  twState_t         state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic             inAck, nextAck;
  logic             startDet, stopDet;

  assign startDet = sclLevel & sdaFall;
  assign stopDet  = sclLevel & sdaRise;

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    nextAck   = inAck;
    ctl       = '0;
    if (startDet) begin
      nextState    = ST_ADDR;
      nextCnt      = '0;
      nextAck      = 1'b0;
      ctl.relDrive = 1'b1;
    end else if (stopDet) begin
      nextState    = ST_IDLE;
      nextCnt      = '0;
      nextAck      = 1'b0;
      ctl.relDrive = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_DATA: begin
          if (inAck) begin
            // ninth clock: leave the acknowledge on its falling edge
            if (sclFall) begin
              ctl.relDrive = 1'b1;
              nextCnt      = '0;
              nextAck      = 1'b0;
              if (state == ST_ADDR) begin
                nextState = ST_CMD;
              end else if (state == ST_CMD && cmdIsRead) begin
                nextState    = ST_TX;
                ctl.relDrive = 1'b0;
                ctl.loadTx   = 1'b1;
              end else if (state == ST_CMD) begin
                nextState = ST_DATA;
              end else begin
                nextState = ST_HOLD;
              end
            end
          end else if (sclRise && bitCnt != FULL) begin
            ctl.shiftIn = 1'b1;
            nextCnt     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            if (state == ST_ADDR && !addrMatch) begin
              nextState = ST_HOLD;
            end else begin
              ctl.ackOn   = 1'b1;
              nextAck     = 1'b1;
              ctl.cmdStb  = (state == ST_CMD);
              ctl.dataStb = (state == ST_DATA);
            end
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt != FULL) begin
            nextCnt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              ctl.relDrive = 1'b1;
              nextState    = ST_TXACK;
              nextCnt      = '0;
            end else begin
              ctl.nextTx = 1'b1;
            end
          end
        end
        ST_TXACK: begin
          // master acknowledge level is not looked at
          if (sclRise) begin
            nextCnt = CNT_W'(1);
          end else if (sclFall && bitCnt != '0) begin
            nextState = ST_HOLD;
            nextCnt   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      inAck  <= 1'b0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
      inAck  <= nextAck;
    end
  end

  a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> state == ST_IDLE);

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0 && !inAck));

  a_r4_cmd_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && $past(state) == ST_ADDR) |-> $past(addrMatch));

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);

endmodule

// File: rtl/tw_data.sv
module tw_data
  import tw_pkg::*;
#(
  parameter int              BITS     = 8,
  parameter int              TYPE_W   = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101,
  parameter int              READ_BIT = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  twCtl_t                 ctl,
  input  logic                   sdaLevel,
  input  logic [BITS-TYPE_W-1:0] strapAddr,
  input  logic [BITS-1:0]        rdByte,
  output logic                   addrMatch,
  output logic                   cmdIsRead,
  output logic                   sdaDriveLow,
  output logic                   cmdValid,
  output logic [BITS-1:0]        cmdByte,
  output logic                   dataValid,
  output logic [BITS-1:0]        dataByte,
  output logic                   rdReq
);

  logic [BITS-1:0] shiftReg;
  logic [BITS-1:0] txReg;

  assign addrMatch = (shiftReg == {DEV_TYPE, strapAddr});
  assign cmdIsRead = shiftReg[READ_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      txReg    <= '0;
    end else begin
      if (ctl.shiftIn) shiftReg <= {shiftReg[BITS-2:0], sdaLevel};
      if (ctl.loadTx)      txReg <= {rdByte[BITS-2:0], 1'b0};
      else if (ctl.nextTx) txReg <= {txReg[BITS-2:0], 1'b0};
    end
  end

  // open-drain enable: a 0 bit on the bus means pull low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaDriveLow <= 1'b0;
    end else if (ctl.relDrive) begin
      sdaDriveLow <= 1'b0;
    end else if (ctl.ackOn) begin
      sdaDriveLow <= 1'b1;
    end else if (ctl.loadTx) begin
      sdaDriveLow <= ~rdByte[BITS-1];
    end else if (ctl.nextTx) begin
      sdaDriveLow <= ~txReg[BITS-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      dataValid <= 1'b0;
      rdReq     <= 1'b0;
      cmdByte   <= '0;
      dataByte  <= '0;
    end else begin
      cmdValid  <= ctl.cmdStb;
      dataValid <= ctl.dataStb;
      rdReq     <= ctl.cmdStb & shiftReg[READ_BIT];
      if (ctl.cmdStb)  cmdByte  <= shiftReg;
      if (ctl.dataStb) dataByte <= shiftReg;
    end
  end

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, dataValid}));

  a_r6_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  a_r8_read_with_cmd: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (cmdValid && cmdByte[READ_BIT]));

endmodule

// File: rtl/tw_slave.sv
module tw_slave
  import tw_pkg::*;
#(
  parameter int                BITS        = 8,
  parameter int                TYPE_W      = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE    = 4'b0101,
  parameter int                READ_BIT    = 7,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [BITS-TYPE_W-1:0] strapAddr,
  input  logic [BITS-1:0]        rdByte,
  output logic                   sdaDriveLow,
  output logic                   cmdValid,
  output logic [BITS-1:0]        cmdByte,
  output logic                   dataValid,
  output logic [BITS-1:0]        dataByte,
  output logic                   rdReq
);

  localparam int LINES = 2;  // index 0 clock, index 1 data

  logic [LINES-1:0] lineRaw, lineLvl, lineRise, lineFall;
  twCtl_t           ctl;
  logic             addrMatch, cmdIsRead;

  assign lineRaw = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (lineRaw[g]),
      .level  (lineLvl[g]),
      .rise   (lineRise[g]),
      .fall   (lineFall[g])
    );
  end

  tw_ctrl #(.BITS(BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclLevel  (lineLvl[0]),
    .sclRise   (lineRise[0]),
    .sclFall   (lineFall[0]),
    .sdaRise   (lineRise[1]),
    .sdaFall   (lineFall[1]),
    .addrMatch (addrMatch),
    .cmdIsRead (cmdIsRead),
    .ctl       (ctl)
  );

  tw_data #(
    .BITS     (BITS),
    .TYPE_W   (TYPE_W),
    .DEV_TYPE (DEV_TYPE),
    .READ_BIT (READ_BIT)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sdaLevel    (lineLvl[1]),
    .strapAddr   (strapAddr),
    .rdByte      (rdByte),
    .addrMatch   (addrMatch),
    .cmdIsRead   (cmdIsRead),
    .sdaDriveLow (sdaDriveLow),
    .cmdValid    (cmdValid),
    .cmdByte     (cmdByte),
    .dataValid   (dataValid),
    .dataByte    (dataByte),
    .rdReq       (rdReq)
  );

  a_r10_pull_only_with_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !lineLvl[0]);

endmodule

// File: tb/tw_slave_bench.sv
module tw_slave_bench;

  localparam int Q = 8;  // system clocks per quarter bus bit

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic [3:0] strap = 4'hA;
  logic [7:0] rdByte = 8'h00;
  logic       sdaDriveLow, cmdValid, dataValid, rdReq;
  logic [7:0] cmdByte, dataByte;
  wire        sdaBus = mSda & ~sdaDriveLow;

  int checks = 0, errors = 0;
  int cmdCnt = 0, dataCnt = 0, rdCnt = 0, bothCnt = 0, badDrive = 0;
  logic [7:0] lastCmd = 8'h00, lastData = 8'h00;
  logic prevDrive = 1'b0;

  always #4 clk = ~clk;

  tw_slave u_tw_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .strapAddr(strap), .rdByte(rdByte), .sdaDriveLow(sdaDriveLow),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .dataValid(dataValid),
    .dataByte(dataByte), .rdReq(rdReq)
  );

  always @(negedge clk) begin
    if (cmdValid) begin cmdCnt++; lastCmd = cmdByte; end
    if (dataValid) begin dataCnt++; lastData = dataByte; end
    if (rdReq) rdCnt++;
    if (rdReq && cmdValid) bothCnt++;
    if (sdaDriveLow && !prevDrive && mScl) badDrive++;
    prevDrive = sdaDriveLow;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mScl = 1'b0; mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    mSda = b;    waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    acked = (sdaBus == 1'b0);
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaBus;
      waitQ();
      mScl = 1'b0; waitQ();
    end
    sendBit(mAck);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    bit ack, ack2;
    logic [7:0] got;
    int c0, d0, r0, b0;
    logic [7:0] wCmd [4] = '{8'h00, 8'h3C, 8'h7F, 8'h55};
    logic [7:0] wDat [4] = '{8'hFF, 8'hA5, 8'h00, 8'h81};
    logic [7:0] rVal [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sdaDriveLow == 0 && cmdValid == 0 && dataValid == 0 && rdReq == 0,
          "R1 reset outputs", {sdaDriveLow, cmdValid, dataValid, rdReq}, 0);

    // R2: bytes without any start
    mScl = 1'b0; waitQ();
    sendByte(8'h5A, ack);
    check(!ack, "R2 no ack before start", ack, 0);
    sendByte(8'h12, ack);
    check(!ack && cmdCnt == 0, "R2 no strobe before start", cmdCnt, 0);
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ();

    // R4/R5: sweep type nibble and strap nibble of the address
    for (int k = 0; k < 32; k++) begin
      logic [7:0] a;
      bit expAck;
      a = (k < 16) ? {4'(k), strap} : {4'h5, 4'(k - 16)};
      expAck = (a == {4'h5, strap});
      c0 = cmdCnt;
      startCond();
      sendByte(a, ack);
      check(ack == expAck, "R4 address sweep ack", ack, expAck);
      sendByte(8'h12, ack2);
      if (expAck) check(ack2 && cmdCnt == c0 + 1, "R6 cmd after match", cmdCnt - c0, 1);
      else check(!ack2 && cmdCnt == c0, "R5 silent after mismatch", {ack2, 8'(cmdCnt - c0)}, 0);
      stopCond();
    end

    // R4: sweep strap pins
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s);
      startCond();
      sendByte({4'h5, 4'(s)}, ack);
      check(ack, "R4 strap match ack", ack, 1);
      stopCond();
      startCond();
      sendByte({4'h5, 4'(s) ^ 4'h1}, ack);
      check(!ack, "R5 strap mismatch no ack", ack, 0);
      stopCond();
    end
    strap = 4'hA;

    // R6/R7: write transactions
    for (int k = 0; k < 4; k++) begin
      c0 = cmdCnt; d0 = dataCnt; r0 = rdCnt;
      startCond();
      sendByte(8'h5A, ack);
      sendByte(wCmd[k], ack);
      check(ack && cmdCnt == c0 + 1 && lastCmd == wCmd[k], "R6 write cmd", lastCmd, wCmd[k]);
      sendByte(wDat[k], ack);
      check(ack && dataCnt == d0 + 1 && lastData == wDat[k], "R7 write data", lastData, wDat[k]);
      check(rdCnt == r0, "R7 write raises no read", rdCnt - r0, 0);
      if (k == 0) begin
        sendByte(8'h99, ack);
        check(!ack && dataCnt == d0 + 1, "R7 byte after data ignored", ack, 0);
      end
      stopCond();
    end

    // R6: command only
    c0 = cmdCnt; d0 = dataCnt;
    startCond();
    sendByte(8'h5A, ack);
    sendByte(8'h21, ack);
    stopCond();
    check(cmdCnt == c0 + 1 && dataCnt == d0 && lastCmd == 8'h21, "R6 command only", lastCmd, 8'h21);

    // R8: read transactions
    for (int k = 0; k < 5; k++) begin
      rdByte = rVal[k];
      r0 = rdCnt; b0 = bothCnt;
      startCond();
      sendByte(8'h5A, ack);
      sendByte(8'h80 | 8'(k), ack);
      check(ack && rdCnt == r0 + 1 && bothCnt == b0 + 1, "R8 read request with cmd", bothCnt - b0, 1);
      readByte(logic'(k & 1), got);
      check(got == rVal[k], "R8 read byte", got, rVal[k]);
      sendByte(8'h00, ack);
      check(!ack, "R8 no drive after read", ack, 0);
      stopCond();
    end

    // R9: repeated start in the middle of a command byte
    c0 = cmdCnt;
    startCond();
    sendByte(8'h5A, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    startCond();
    sendByte(8'h5A, ack);
    check(ack, "R9 address after restart", ack, 1);
    sendByte(8'h2B, ack);
    stopCond();
    check(cmdCnt == c0 + 1 && lastCmd == 8'h2B, "R9 cmd after restart", lastCmd, 8'h2B);

    // R9: restart rescues a mismatched transaction
    startCond();
    sendByte(8'h4A, ack);
    startCond();
    sendByte(8'h5A, ack);
    check(ack, "R9 restart after mismatch", ack, 1);
    stopCond();

    // R3: after a stop, no start: ignored
    c0 = cmdCnt;
    mScl = 1'b0; waitQ();
    sendByte(8'h5A, ack);
    check(!ack, "R3 no ack after stop", ack, 0);
    sendByte(8'h33, ack);
    check(!ack && cmdCnt == c0, "R3 no strobe after stop", cmdCnt - c0, 0);
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ();

    // R10: pull-low only ever began with the clock low
    check(badDrive == 0, "R10 drive only with clock low", badDrive, 0);

    finishRun();
  end

endmodule